// File: doc/BRIEF.md
# Wrapping Burst Read Controller

This block is the device side of a synchronous burst read port on a word-addressed memory. The host pulls the chip enable and the address-valid strobe low with output enable high. The block then captures a start address and counts a programmable number of wait states. After that it streams one word per clock from a small internal array. The burst pointer either counts through the whole address space or wraps inside an aligned group of 8, 16 or 32 words. The wrap always starts at the captured address and returns to the lowest word of that group.

A ready output tells the host when data is valid, so the host can wait for it instead of counting cycles. A configuration register sets these options:

- the wait count
- the burst ordering
- whether outputs change on the rising or the falling clock edge
- whether ready leads the data by a cycle
- the polarity of ready
- whether the port works synchronously at all

In asynchronous mode the clock has no effect and the port behaves as a plain combinational read.

Top module: `burst_rd_ctrl`

## Requirements
- R1: After reset the configuration is asynchronous, continuous ordering, wait count 7, rising edge, same-cycle ready, active-high ready. With the chip enable high, `rdy` is 0 and `dout` is 0.
- R2: A rising edge with `cfg_we` high loads `cfg_wdata`. The bit fields are: [2:0] wait count W, [4:3] ordering (0 continuous, 1 wrap-8, 2 wrap-16, 3 wrap-32), [5] falling-edge output, [6] early ready, [7] active-low ready, [8] synchronous enable. The load takes effect from the next edge.
- R3: In synchronous mode, a rising edge that sees `ce_n`=0, `adv_n`=0 and `oe_n`=1 captures `addr` and restarts the wait count. This also applies in the middle of a burst.
- R4: With wait count W and the capture at edge L, the first word is output after edge L+W+1. Before that, `rdy` is inactive and `dout` is 0.
- R5: While `ce_n` and `oe_n` are low, each following rising edge presents the next word. The word stored at address a reads as {~a, a}.
- R6: In the wrap modes of group size G, only the low log2(G) address bits count, modulo G, and the upper bits stay fixed. For example, start 39h in wrap-8 gives 39, 3A ... 3F, 38, 39.
- R7: In continuous mode the full address increments and rolls over from the top address to 0.
- R8: With early ready set, `rdy` becomes active one cycle before the first word. Without it, `rdy` becomes active together with the first word.
- R9: With the active-low bit set, `rdy` is the inverse of the active-high form in every cycle.
- R10: With falling-edge output selected, `rdy` and `dout` change at the falling edge that follows the rising edge that advanced the burst.
- R11: `ce_n` high at a rising edge, or `oe_n` high at a rising edge during the data phase, ends the burst. `oe_n` going low again without a new capture does not restart it.
- R12: In asynchronous mode, `dout` is the word at `addr` and `rdy` is active whenever `ce_n` and `oe_n` are both low. Otherwise `dout` is 0 and `rdy` is inactive. Clock edges and `adv_n` have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Burst clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration load strobe |
| cfg_wdata | input | 9 | Configuration value |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| adv_n | input | 1 | Address-valid strobe, active low |
| addr | input | AW (8) | Word address |
| rdy | output | 1 | Data-ready indication, polarity per configuration |
| dout | output | 2*AW (16) | Read data |

## Verification
The assertions check the following on every cycle:
- a qualifying strobe loads the pointer and the wait counter
- the wait phase keeps ready quiet
- an active burst keeps streaming
- chip-enable loss or asynchronous mode forces the sequencer idle
- a wrap-8 burst never changes the upper pointer bits

Only the bench's scenarios can show some behaviours:
- the exact cycle of the first word for every wait count
- the full wrap and rollover address order seen on `dout`
- the one-cycle lead of early ready
- the half-cycle shift in falling-edge mode
- that a burst stays dead after `oe_n` returns low

// File: rtl/brc_pkg.sv
`timescale 1ns/1ps
package brc_pkg;

    localparam int WAIT_W = 3;

    typedef enum logic [1:0] {
        BM_LINEAR = 2'd0,
        BM_WRAP8  = 2'd1,
        BM_WRAP16 = 2'd2,
        BM_WRAP32 = 2'd3
    } bmode_e;

    // Field order fixes the bit layout of the load value: sync_en is bit 8.
    typedef struct packed {
        logic              sync_en;
        logic              rdy_low;
        logic              rdy_early;
        logic              fall_edge;
        bmode_e            mode;
        logic [WAIT_W-1:0] wait_n;
    } cfg_t;

    localparam int CFG_W = $bits(cfg_t);

    localparam cfg_t CFG_RST = '{
        sync_en:   1'b0,
        rdy_low:   1'b0,
        rdy_early: 1'b0,
        fall_edge: 1'b0,
        mode:      BM_LINEAR,
        wait_n:    {WAIT_W{1'b1}}
    };

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_WAIT  = 2'd1,
        S_BURST = 2'd2
    } st_e;

    typedef struct packed {
        logic rdy;
        logic vld;
    } obeat_t;

endpackage

// File: rtl/brc_cfg.sv
`timescale 1ns/1ps
module brc_cfg
    import brc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    output cfg_t             cfg
);

    always_ff @(posedge clk) begin
        if (rst)
            cfg <= CFG_RST;
        else if (we)
            cfg <= cfg_t'(wdata);
    end

endmodule

// File: rtl/brc_seq.sv
`timescale 1ns/1ps
module brc_seq
    import brc_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  cfg_t              cfg,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              adv_n,
    input  logic [AW-1:0]     addr,
    output st_e               st,
    output logic [WAIT_W-1:0] cnt,
    output logic [AW-1:0]     ptr
);

    localparam int NGRP = 3;   // wrap groups of 8, 16, 32 words
    localparam int GB0  = 3;   // log2 of the smallest group

    logic [AW-1:0] nxt_wrap [NGRP];
    logic [AW-1:0] nxt;

    // One wrap incrementer per group size: low bits count, upper bits stay.
    for (genvar gi = 0; gi < NGRP; gi++) begin : g_wrap
        localparam int GB = GB0 + gi;
        assign nxt_wrap[gi] = {ptr[AW-1:GB], ptr[GB-1:0] + GB'(1)};
    end

    always_comb begin
        unique case (cfg.mode)
            BM_WRAP8:  nxt = nxt_wrap[0];
            BM_WRAP16: nxt = nxt_wrap[1];
            BM_WRAP32: nxt = nxt_wrap[2];
            default:   nxt = ptr + AW'(1);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= S_IDLE;
            cnt <= '0;
            ptr <= '0;
        end else if (!cfg.sync_en || ce_n) begin
            st  <= S_IDLE;
            cnt <= '0;
        end else if (!adv_n && oe_n) begin
            st  <= S_WAIT;
            cnt <= cfg.wait_n;
            ptr <= addr;
        end else begin
            unique case (st)
                S_WAIT: begin
                    if (cnt == '0)
                        st <= S_BURST;
                    else
                        cnt <= cnt - WAIT_W'(1);
                end
                S_BURST: begin
                    if (oe_n)
                        st <= S_IDLE;
                    else
                        ptr <= nxt;
                end
                default: st <= S_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/brc_out.sv
`timescale 1ns/1ps
module brc_out
    import brc_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  cfg_t              cfg,
    input  st_e               st,
    input  logic [WAIT_W-1:0] cnt,
    input  logic [AW-1:0]     ptr,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic [AW-1:0]     addr,
    output logic              rdy,
    output logic [2*AW-1:0]   dout
);

    localparam int DW    = 2 * AW;
    localparam int DEPTH = 1 << AW;

    // Behavioural array: word a holds {~a, a}.
    logic [DW-1:0] mem [DEPTH];
    for (genvar i = 0; i < DEPTH; i++) begin : g_mem
        localparam logic [AW-1:0] A = AW'(i);
        assign mem[i] = {~A, A};
    end

    obeat_t        core_b, neg_b, sel_b;
    logic [DW-1:0] core_d, neg_d, sel_d;
    logic          acc, rdy_act;

    always_comb begin
        core_b.vld = (st == S_BURST);
        core_b.rdy = core_b.vld ||
                     (cfg.rdy_early && st == S_WAIT && cnt == '0);
        core_d     = core_b.vld ? mem[ptr] : '0;
    end

    // Half-cycle retiming stage for falling-edge output.
    always_ff @(negedge clk) begin
        if (rst) begin
            neg_b <= '0;
            neg_d <= '0;
        end else begin
            neg_b <= core_b;
            neg_d <= core_d;
        end
    end

    assign sel_b = cfg.fall_edge ? neg_b : core_b;
    assign sel_d = cfg.fall_edge ? neg_d : core_d;
    assign acc   = !ce_n && !oe_n;

    always_comb begin
        if (!cfg.sync_en) begin
            rdy_act = acc;
            dout    = acc ? mem[addr] : '0;
        end else begin
            rdy_act = acc && sel_b.rdy;
            dout    = (acc && sel_b.vld) ? sel_d : '0;
        end
    end

    assign rdy = rdy_act ^ cfg.rdy_low;

endmodule

// File: rtl/burst_rd_ctrl.sv
`timescale 1ns/1ps
module burst_rd_ctrl
    import brc_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             ce_n,
    input  logic             oe_n,
    input  logic             adv_n,
    input  logic [AW-1:0]    addr,
    output logic             rdy,
    output logic [2*AW-1:0]  dout
);

    cfg_t              cfg;
    st_e               st;
    logic [WAIT_W-1:0] cnt;
    logic [AW-1:0]     ptr;

    brc_cfg u_cfg (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .cfg   (cfg)
    );

    brc_seq #(.AW(AW)) u_seq (
        .clk   (clk),
        .rst   (rst),
        .cfg   (cfg),
        .ce_n  (ce_n),
        .oe_n  (oe_n),
        .adv_n (adv_n),
        .addr  (addr),
        .st    (st),
        .cnt   (cnt),
        .ptr   (ptr)
    );

    brc_out #(.AW(AW)) u_out (
        .clk   (clk),
        .rst   (rst),
        .cfg   (cfg),
        .st    (st),
        .cnt   (cnt),
        .ptr   (ptr),
        .ce_n  (ce_n),
        .oe_n  (oe_n),
        .addr  (addr),
        .rdy   (rdy),
        .dout  (dout)
    );

endmodule

// File: rtl/brc_chk.sv
`timescale 1ns/1ps
module brc_chk
    import brc_pkg::*;
#(
    parameter int AW = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              ce_n,
    input logic              oe_n,
    input logic              adv_n,
    input logic [AW-1:0]     addr,
    input logic              rdy,
    input cfg_t              cfg,
    input st_e               st,
    input logic [WAIT_W-1:0] cnt,
    input logic [AW-1:0]     ptr
);

    a_r1_cfg_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> cfg == CFG_RST);

    a_r3_capture: assert property (@(posedge clk) disable iff (rst)
        (cfg.sync_en && !ce_n && !adv_n && oe_n) |=>
        (st == S_WAIT && ptr == $past(addr) && cnt == $past(cfg.wait_n)));

    a_r4_rdy_quiet: assert property (@(posedge clk) disable iff (rst)
        (!cfg.fall_edge && st == S_WAIT && cnt != '0) |-> rdy == cfg.rdy_low);

    a_r5_keep_streaming: assert property (@(posedge clk) disable iff (rst)
        (cfg.sync_en && st == S_BURST && !ce_n && !oe_n && adv_n) |=>
        st == S_BURST);

    a_r6_wrap8_upper: assert property (@(posedge clk) disable iff (rst)
        (st == S_BURST && !ce_n && !oe_n && adv_n && cfg.mode == BM_WRAP8) |=>
        ptr[AW-1:3] == $past(ptr[AW-1:3]));

    a_r11_ce_abort: assert property (@(posedge clk) disable iff (rst)
        ce_n |=> st == S_IDLE);

    a_r12_async_idle: assert property (@(posedge clk) disable iff (rst)
        !cfg.sync_en |=> st == S_IDLE);

endmodule

bind burst_rd_ctrl brc_chk #(.AW(AW)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .ce_n  (ce_n),
    .oe_n  (oe_n),
    .adv_n (adv_n),
    .addr  (addr),
    .rdy   (rdy),
    .cfg   (cfg),
    .st    (st),
    .cnt   (cnt),
    .ptr   (ptr)
);

// File: tb/tb_burst_rd_ctrl.sv
`timescale 1ns/1ps
module tb_burst_rd_ctrl;

    localparam int AW = 8;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_we = 1'b0;
    logic [8:0]    cfg_wdata = '0;
    logic          ce_n = 1'b1;
    logic          oe_n = 1'b1;
    logic          adv_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic          rdy;
    logic [DW-1:0] dout;

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    burst_rd_ctrl #(.AW(AW)) dut (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .ce_n      (ce_n),
        .oe_n      (oe_n),
        .adv_n     (adv_n),
        .addr      (addr),
        .rdy       (rdy),
        .dout      (dout)
    );

    function automatic logic [DW-1:0] word_of(logic [AW-1:0] a);
        return {~a, a};
    endfunction

    function automatic logic [AW-1:0] step_addr(logic [AW-1:0] a, int m);
        int g;
        int v;
        if (m == 0) return a + AW'(1);
        g = 4 << m;
        v = (int'(a) & ~(g - 1)) | ((int'(a) + 1) & (g - 1));
        return AW'(v);
    endfunction

    function automatic logic [8:0] mk_cfg(bit sync, bit low, bit early,
                                          bit fall, int m, int w);
        return {sync, low, early, fall, 2'(m), 3'(w)};
    endfunction

    task automatic chk(string r, logic [DW-1:0] act, logic [DW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h t=%0t", r, act, exp, $time);
        end
    endtask

    task automatic load_cfg(logic [8:0] v);
        @(posedge clk);
        #1 cfg_we = 1'b1; cfg_wdata = v;
        @(posedge clk);
        #1 cfg_we = 1'b0;
    endtask

    // Full burst; ends at the sample point of the last beat with CE released.
    task automatic run_burst(logic [AW-1:0] start, int m, int w, bit early,
                             bit low, bit fall, int nb);
        logic [AW-1:0] a;
        string tg;
        bit exp_act;
        tg = (m == 0) ? "R7" : "R6";
        load_cfg(mk_cfg(1'b1, low, early, fall, m, w));
        ce_n = 1'b0; adv_n = 1'b0; oe_n = 1'b1; addr = start;
        @(posedge clk);
        #1 adv_n = 1'b1; oe_n = 1'b0;
        #6;
        a = start;
        for (int j = 0; j <= w + nb; j++) begin
            if (j > 0) begin
                @(posedge clk);
                if (fall && j == w + 1) begin
                    #2 chk("R10 old data until falling edge", dout, '0);
                    #5;
                end else begin
                    #7;
                end
            end
            if (j <= w) begin
                exp_act = early && (j == w);
                chk(early ? "R8 early rdy" : "R4 rdy quiet in wait",
                    {15'd0, rdy}, {15'd0, exp_act ^ low});
                chk("R4 no data in wait", dout, '0);
            end else begin
                chk(low ? "R9 rdy active-low in data" : "R5 rdy in data",
                    {15'd0, rdy}, {15'd0, ~low});
                if (j == w + 1)
                    chk("R2 R4 first word timing", dout, word_of(a));
                else
                    chk(tg, dout, word_of(a));
                a = step_addr(a, m);
            end
        end
        ce_n = 1'b1; oe_n = 1'b1;
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            total++; bad++;
            $display("FAIL R5 watchdog act=hung exp=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        #6;
        // R1 reset state
        chk("R1 rdy after reset", {15'd0, rdy}, 16'd0);
        chk("R1 dout after reset", dout, '0);

        // R1/R12: default config is asynchronous
        ce_n = 1'b0; oe_n = 1'b0; addr = 8'h5A;
        #1 chk("R1 async default", dout, word_of(8'h5A));
        chk("R12 async rdy", {15'd0, rdy}, 16'd1);
        for (int k = 0; k < 4; k++) begin
            @(posedge clk);
            #3 adv_n = ~adv_n; addr = 8'(8'h30 + k * 7);
            #1 chk("R12 async follows addr", dout, word_of(8'(8'h30 + k * 7)));
        end
        adv_n = 1'b1;
        oe_n = 1'b1;
        #1 chk("R12 async oe high", dout, '0);
        chk("R12 async oe high rdy", {15'd0, rdy}, 16'd0);
        ce_n = 1'b1;

        // Directed bursts
        run_burst(8'h39, 1, 2, 1'b0, 1'b0, 1'b0, 10);   // R6 example
        run_burst(8'h1E, 2, 0, 1'b0, 1'b0, 1'b0, 20);   // R6 wrap16, W=0
        run_burst(8'h3D, 3, 7, 1'b0, 1'b0, 1'b0, 36);   // R6 wrap32, W=7
        run_burst(8'hFD, 0, 1, 1'b0, 1'b0, 1'b0, 6);    // R7 rollover
        run_burst(8'h42, 1, 3, 1'b1, 1'b0, 1'b0, 4);    // R8
        run_burst(8'h07, 2, 0, 1'b1, 1'b0, 1'b0, 4);    // R8 with W=0
        run_burst(8'h90, 0, 2, 1'b0, 1'b1, 1'b0, 5);    // R9
        run_burst(8'hA5, 1, 4, 1'b1, 1'b1, 1'b1, 12);   // R10 with R8, R9

        // R3 restart mid-burst, then R11 aborts
        load_cfg(mk_cfg(1'b1, 1'b0, 1'b0, 1'b0, 1, 1));
        ce_n = 1'b0; adv_n = 1'b0; oe_n = 1'b1; addr = 8'h10;
        @(posedge clk);
        #1 adv_n = 1'b1; oe_n = 1'b0;
        repeat (3) @(posedge clk);
        #7 chk("R5 second beat", dout, word_of(8'h11));
        oe_n = 1'b1; adv_n = 1'b0; addr = 8'h44;
        @(posedge clk);
        #1 adv_n = 1'b1; oe_n = 1'b0;
        #6 chk("R3 restart wait data", dout, '0);
        chk("R3 restart wait rdy", {15'd0, rdy}, 16'd0);
        repeat (2) @(posedge clk);
        #7 chk("R3 restart first word", dout, word_of(8'h44));
        oe_n = 1'b1;
        @(posedge clk);
        #7 oe_n = 1'b0;
        #1 chk("R11 oe abort data", dout, '0);
        chk("R11 oe abort rdy", {15'd0, rdy}, 16'd0);
        @(posedge clk);
        #7 chk("R11 no resume", dout, '0);
        ce_n = 1'b1;
        @(posedge clk);
        #1 ce_n = 1'b0; adv_n = 1'b0; oe_n = 1'b1; addr = 8'h20;
        @(posedge clk);
        #1 adv_n = 1'b1; oe_n = 1'b0;
        repeat (2) @(posedge clk);
        #7 chk("R5 burst before ce abort", dout, word_of(8'h20));
        ce_n = 1'b1;
        @(posedge clk);
        #7 ce_n = 1'b0;
        #1 chk("R11 ce abort", dout, '0);
        chk("R11 ce abort rdy", {15'd0, rdy}, 16'd0);
        ce_n = 1'b1; oe_n = 1'b1;

        // Random bursts
        for (int n = 0; n < 30; n++) begin
            run_burst(AW'($urandom_range(0, 255)), int'($urandom_range(0, 3)),
                      int'($urandom_range(0, 7)), 1'($urandom_range(0, 1)),
                      1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                      int'($urandom_range(1, 40)));
        end

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule